// File: doc/BRIEF.md
# Configurable Fault Injection Cell

This cell sits on one target signal and produces the replacement signal that the surrounding logic reads instead of the original. A single control line (`fis_i`) switches the fault on. The kind of fault is fixed when the cell is built, through the `KIND` parameter. There are four kinds. Two are permanent: force all bits low, or force all bits high. One is timed: it inverts the signal for a set number of cycles. The last is a register upset: one bit of a captured value is inverted.

The permanent kinds act at once while the control line is high. The timed and upset kinds act on a low-to-high change of the control line. In the timed kind, that change starts a down-counter, and the output stays inverted until the counter reaches zero. The upset kind wraps a register bit cell: the target signal is the register's D input and the cell's output is its Q. On a control rising edge, if the arm input is high, one bit of the value being captured is inverted.

In the upset kind, the inverted bit comes from a 127-entry table of bell-shaped values, reduced modulo the width. A free-running counter walks through that table.

Top module: `fi_cell`

## Requirements
- R1: While `fis_i` stays low, the stuck and timed kinds pass `sig_i` to `sig_o` unchanged in the same cycle. The upset kind shows on `sig_o` the `sig_i` value sampled at the previous clock edge.
- R2: Kind 0 (stuck-low): while `fis_i` is 1, every bit of `sig_o` is 0.
- R3: Kind 1 (stuck-high): while `fis_i` is 1, every bit of `sig_o` is 1.
- R4: Kind 2 (timed): a clock edge that samples `fis_i`=1 after sampling 0 at the edge before starts the fault. `sig_o` = ~`sig_i` for exactly `PULSE_LEN` cycles after that edge, whether `fis_i` is then held high or dropped.
- R5: A new rising edge of `fis_i` during an active timed fault reloads the full `PULSE_LEN` count.
- R6: Kind 3 (upset): when an edge sees `fis_i` rising and `arm_i`=1, the captured value is `sig_i` with exactly one bit inverted. At later edges where `fis_i` stays high, `sig_i` is loaded unaltered.
- R7: Kind 3: if `arm_i` is 0 at the edge where `fis_i` rises, no bit is inverted. Raising `arm_i` later, while `fis_i` is still high, inverts nothing either.
- R8: The upset bit index is E(c) mod `WIDTH`, where c is a counter that is 0 in reset, advances by 1 at every clock edge and returns to 0 after 126. The table entry is E(c) = (5c+1)%16 + (7c+3)%16 + (11c+6)%16 + (13c+9)%16.
- R9: During reset (`rst_n`=0) the upset register reads all zeros and no timed fault is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fis_i | input | 1 | Fault activation line |
| arm_i | input | 1 | Per-bit enable for the upset kind |
| sig_i | input | WIDTH | Original target signal |
| sig_o | output | WIDTH | Replacement signal |

## Verification
All four kinds are built side by side at a width of four bits and driven from one set of inputs.

All sixteen data values are swept twice, once with the control line low and once with it high. This shows that the permanent kinds pass data through when idle and force it when active. The same sweep shows that the upset register's one-cycle delay is a plain load.

The timed kind gets two control patterns. One holds the control line high well past the pulse length, which shows that the level does not stretch the fault. The other re-raises the control line mid-pulse, which tells a reload apart from a single fixed window. Data changes on every cycle of both patterns, so inversion is told apart from a frozen value.

For the upset kind, the bench fires more than 127 armed pulses three cycles apart. Because three and 127 share no factor, every counter value is hit, and every inverted bit is checked against the table formula. The cycle after each pulse shows the flip happens only once. Unarmed pulses, and arming late while the control line is held high, must leave the data untouched.

// File: rtl/fi_pkg.sv
package fi_pkg;

   typedef enum logic [1:0] {
      FI_STUCK0    = 2'd0,
      FI_STUCK1    = 2'd1,
      FI_TRANSIENT = 2'd2,
      FI_BITFLIP   = 2'd3
   } fi_kind_e;

   // Length of the walk through the selection table before it wraps.
   localparam int unsigned PICK_SPAN = 127;
   localparam int unsigned PICK_CW   = 7;

   // Bell-shaped entry: a sum of four scrambled uniform terms.
   function automatic int unsigned gauss_entry(input int unsigned c);
      return ((c * 5 + 1) % 16) + ((c * 7 + 3) % 16)
           + ((c * 11 + 6) % 16) + ((c * 13 + 9) % 16);
   endfunction

endpackage

// File: rtl/fi_rise_detect.sv
module fi_rise_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~lvl_q;

endmodule

// File: rtl/fi_pulse_timer.sv
module fi_pulse_timer #(
   parameter int unsigned LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic active_o
);
   localparam int unsigned CW = $clog2(LEN + 1);

   logic [CW-1:0] remain_q;

   initial assert (LEN >= 1) else $fatal(1, "fi_pulse_timer: LEN must be at least 1");

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               remain_q <= '0;
      else if (start_i)         remain_q <= CW'(LEN);
      else if (remain_q != '0)  remain_q <= remain_q - 1'b1;
   end

   assign active_o = (remain_q != '0);

   // R4 / R5: every start loads the full length.
   p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (remain_q == CW'(LEN)));

   // R4: without a start the count only moves down by one.
   p_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && remain_q != '0) |=> (remain_q == $past(remain_q) - 1'b1));

endmodule

// File: rtl/fi_bit_picker.sv
module fi_bit_picker #(
   parameter int unsigned WIDTH = 8
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   output logic [((WIDTH > 1) ? $clog2(WIDTH) : 1)-1:0] idx_o
);
   localparam int unsigned IW   = (WIDTH > 1) ? $clog2(WIDTH) : 1;
   localparam int unsigned CW   = fi_pkg::PICK_CW;
   localparam int unsigned LAST = fi_pkg::PICK_SPAN - 1;

   logic [CW-1:0] walk_q;
   logic [IW-1:0] table_w [0:(1 << CW) - 1];

   // Table is computed at elaboration; the unused top slot is filled too.
   for (genvar g = 0; g < (1 << CW); g++) begin : g_tab
      assign table_w[g] = IW'(fi_pkg::gauss_entry(g) % WIDTH);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  walk_q <= '0;
      else if (walk_q == CW'(LAST)) walk_q <= '0;
      else                         walk_q <= walk_q + 1'b1;
   end

   assign idx_o = table_w[walk_q];

   // R8: the walk wraps after the last table slot.
   p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_q == CW'(LAST)) |=> (walk_q == '0));

   // R8: otherwise it steps by one every edge.
   p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_q != CW'(LAST)) |=> (walk_q == $past(walk_q) + 1'b1));

endmodule

// File: rtl/fi_cell.sv
module fi_cell #(
   parameter int unsigned      WIDTH     = 8,
   parameter fi_pkg::fi_kind_e KIND      = fi_pkg::FI_STUCK0,
   parameter int unsigned      PULSE_LEN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fis_i,
   input  logic             arm_i,
   input  logic [WIDTH-1:0] sig_i,
   output logic [WIDTH-1:0] sig_o
);
   localparam int unsigned IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

   initial assert (WIDTH >= 1) else $fatal(1, "fi_cell: WIDTH must be at least 1");
   initial assert (PULSE_LEN >= 1) else $fatal(1, "fi_cell: PULSE_LEN must be at least 1");

   logic fis_rise;

   fi_rise_detect u_rise (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (fis_i),
      .rise_o (fis_rise)
   );

   if (KIND == fi_pkg::FI_STUCK0) begin : g_stuck0
      logic unused_sink;
      assign unused_sink = ^{arm_i, fis_rise};
      assign sig_o = fis_i ? '0 : sig_i;

      p_force0_r2: assert property (@(posedge clk) disable iff (!rst_n)
         fis_i |-> (sig_o == '0));
      p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
         !fis_i |-> (sig_o == sig_i));

   end else if (KIND == fi_pkg::FI_STUCK1) begin : g_stuck1
      logic unused_sink;
      assign unused_sink = ^{arm_i, fis_rise};
      assign sig_o = fis_i ? '1 : sig_i;

      p_force1_r3: assert property (@(posedge clk) disable iff (!rst_n)
         fis_i |-> (sig_o == '1));
      p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
         !fis_i |-> (sig_o == sig_i));

   end else if (KIND == fi_pkg::FI_TRANSIENT) begin : g_trans
      logic unused_sink;
      logic hit;
      assign unused_sink = arm_i;

      fi_pulse_timer #(.LEN(PULSE_LEN)) u_timer (
         .clk      (clk),
         .rst_n    (rst_n),
         .start_i  (fis_rise),
         .active_o (hit)
      );

      assign sig_o = hit ? ~sig_i : sig_i;

      // R4: a start is visible on the port one edge later.
      p_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
         fis_rise |=> (sig_o == ~sig_i));

   end else begin : g_flip
      logic [IW-1:0]    pick;
      logic [WIDTH-1:0] mask;
      logic [WIDTH-1:0] cap_q;

      fi_bit_picker #(.WIDTH(WIDTH)) u_pick (
         .clk   (clk),
         .rst_n (rst_n),
         .idx_o (pick)
      );

      assign mask = (fis_rise & arm_i) ? (WIDTH'(1) << pick) : '0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cap_q <= '0;
         else        cap_q <= sig_i ^ mask;
      end

      assign sig_o = cap_q;

      // R6: an armed rising edge corrupts exactly one bit.
      p_one_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (fis_rise && arm_i) |=> ($countones(sig_o ^ $past(sig_i)) == 1));

      // R1 / R7: otherwise the register loads the input unchanged.
      p_clean_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !(fis_rise && arm_i) |=> (sig_o == $past(sig_i)));
   end

endmodule

// File: tb/tb_fi_cell.sv
module tb_fi_cell;
   localparam int unsigned W          = 4;
   localparam int unsigned LEN        = 3;
   localparam time         CLK_PERIOD = 10ns;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         fis = 1'b0;
   logic         arm = 1'b0;
   logic [W-1:0] din = '0;
   logic [W-1:0] dout [4];

   int n_run  = 0;
   int n_fail = 0;
   int bc     = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   for (genvar k = 0; k < 4; k++) begin : g_mode
      fi_cell #(.WIDTH(W), .KIND(fi_pkg::fi_kind_e'(k)), .PULSE_LEN(LEN)) dut (
         .clk   (clk),
         .rst_n (rst_n),
         .fis_i (fis),
         .arm_i (arm),
         .sig_i (din),
         .sig_o (dout[k])
      );
   end

   // Cycle counter from R8: 0 in reset, +1 per edge, back to 0 after 126.
   always @(posedge clk) begin
      if (!rst_n)        bc <= 0;
      else if (bc == 126) bc <= 0;
      else               bc <= bc + 1;
   end

   function automatic int exp_bit(input int c);
      int s;
      s = (5 * c + 1) % 16 + (7 * c + 3) % 16 + (11 * c + 6) % 16 + (13 * c + 9) % 16;
      return s % W;
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic report;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
   end

   initial begin
      logic [W-1:0] v;
      logic [W-1:0] exp;
      int           idx;

      // R9: reset state.
      din = 4'hA;
      repeat (3) @(negedge clk);
      check("R9 upset reg in reset", dout[3], '0);
      check("R9 timed idle in reset", dout[2], 4'hA);
      rst_n = 1'b1;

      // R1: idle sweep of all data values.
      for (int i = 0; i < 16; i++) begin
         @(negedge clk);
         din = W'(i);
         #1;
         check("R1 stuck0 idle", dout[0], W'(i));
         check("R1 stuck1 idle", dout[1], W'(i));
         check("R1 timed idle", dout[2], W'(i));
         @(negedge clk);
         check("R1 upset delayed load", dout[3], W'(i));
      end

      // R2 / R3: forced sweep.
      @(negedge clk);
      fis = 1'b1;
      for (int i = 0; i < 16; i++) begin
         din = W'(15 - i);
         #1;
         check("R2 stuck0 forced", dout[0], '0);
         check("R3 stuck1 forced", dout[1], '1);
         @(negedge clk);
      end
      fis = 1'b0;
      repeat (LEN + 2) @(negedge clk);

      // R4: held high well past the pulse length.
      din = 4'h6;
      fis = 1'b1;
      #1;
      check("R4 timed not before edge", dout[2], 4'h6);
      for (int k = 1; k <= LEN + 2; k++) begin
         @(negedge clk);
         exp = (k <= LEN) ? ~din : din;
         check("R4 timed window held", dout[2], exp);
         din = din + 4'd3;
      end
      fis = 1'b0;
      repeat (2) @(negedge clk);

      // R4 / R5: drop, then re-raise mid-pulse.
      fis = 1'b1;
      @(negedge clk);
      check("R4 timed window dropped", dout[2], ~din);
      fis = 1'b0;
      din = 4'h9;
      @(negedge clk);
      check("R4 timed window continues", dout[2], ~din);
      fis = 1'b1;
      for (int k = 1; k <= LEN + 1; k++) begin
         @(negedge clk);
         exp = (k <= LEN) ? ~din : din;
         check("R5 timed reload", dout[2], exp);
         if (k == 1) fis = 1'b0;
         din = din + 4'd5;
      end
      repeat (2) @(negedge clk);

      // R6 / R8: armed pulses covering every counter value.
      arm = 1'b1;
      for (int p = 0; p < 130; p++) begin
         @(negedge clk);
         v   = W'(p * 7 + 3);
         din = v;
         fis = 1'b1;
         idx = exp_bit(bc);
         @(negedge clk);
         check("R8 upset flipped bit", dout[3], v ^ (W'(1) << idx));
         din = W'(p);
         @(negedge clk);
         check("R6 upset once per rise", dout[3], W'(p));
         fis = 1'b0;
      end

      // R7: unarmed rise, then late arming while held high.
      @(negedge clk);
      arm = 1'b0;
      din = 4'h9;
      fis = 1'b1;
      @(negedge clk);
      check("R7 unarmed rise", dout[3], 4'h9);
      arm = 1'b1;
      din = 4'h5;
      @(negedge clk);
      check("R7 late arm", dout[3], 4'h5);
      fis = 1'b0;
      arm = 1'b0;
      @(negedge clk);

      report();
   end

endmodule